// File: doc/BRIEF.md
# PCIe Link Training Supervisor

This block watches a PCIe link once training has been enabled and decides when the link can be used. On each poll it first checks one debug status word for "link up and not training". If the link is not up yet, it reads the PHY receive-status register through a request/acknowledge port to a PHY register access engine. It then compares that register and the training state code in a second debug word against a known stuck condition. The stuck condition is a link that hangs while switching to the second-generation rate.

When the link is stuck, the supervisor pulses the receiver data-enable and PLL-enable overrides in a PHY override register. It does this with read-modify-write accesses and a timed hold between them. Polls are spaced by a timer derived from a cycles-per-microsecond parameter. After a fixed number of unsuccessful polls the supervisor gives up and flags a timeout. A PHY access error ends the run at once with a failure. A single start pulse arms the block, and the result stays on the outputs until the next start.

Top module: `link_train_sup`

## Requirements
- R1: When dbgWord1 bit 4 is 1 and bit 29 is 0 at a poll, the supervisor finishes with done=1, linkOk=1, timeout=0, and makes no further PHY access.
- R2: A poll where the link is not up issues exactly one PHY read (phyWe=0) of address 0x100D.
- R3: Recovery starts only when dbgWord0[5:0] equals 0x0D and bit 0 of the 0x100D read data is 0. Otherwise the poll makes no PHY write.
- R4: Recovery first reads address 0x1005, then writes it back with bits 5 and 3 set and all other bits unchanged.
- R5: Between the acknowledge of the first override write and the request of the next read there are exactly HOLD_US*CLK_PER_US cycles without a request.
- R6: Recovery then reads 0x1005 again and writes back the value just read, with bits 5 and 3 cleared.
- R7: Between two receive-status reads of polls that take no action there are exactly POLL_US*CLK_PER_US+2 cycles without a request.
- R8: After MAX_POLLS polls without link up, the supervisor finishes with done=1, timeout=1, linkOk=0.
- R9: An acknowledge with phyErr=1 ends the run with done=1, linkOk=0, timeout=0, and no further request follows.
- R10: Once raised, phyReq stays high with phyAddr, phyWe and phyWdata unchanged until phyAck. No request is made while done is high.
- R11: done, linkOk and timeout hold until the next start. A start in the done state clears them and begins a fresh run with a zeroed poll count.
- R12: After reset, done, linkOk, timeout and phyReq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a supervision run (accepted when idle or done) |
| dbgWord0 | input | 32 | Debug word holding the training state code in bits 5:0 |
| dbgWord1 | input | 32 | Debug word with link-up (bit 4) and in-training (bit 29) |
| phyReq | output | 1 | PHY register access request |
| phyWe | output | 1 | 1 = write, 0 = read |
| phyAddr | output | 16 | PHY register address |
| phyWdata | output | 16 | PHY write data |
| phyAck | input | 1 | One-cycle access completion |
| phyErr | input | 1 | Access error, valid with phyAck |
| phyRdata | input | 16 | PHY read data, valid with phyAck |
| done | output | 1 | Run finished |
| linkOk | output | 1 | Run finished with link up |
| timeout | output | 1 | Run finished after the poll limit |

## Verification
The sweep covers every combination of the link-up and in-training bits, the receive-valid bit, and a stuck or non-stuck state code. The state code is padded with random-looking upper bits, so the sweep shows that only the up/not-training pair ends a run early. It also shows that only the stuck pair triggers override writes, and that other cases poll silently to the timeout. Further cases cover a link that comes up mid-run and an access error. A change made to the override register during the hold proves that the second write uses fresh read data. The bench also measures request-free gaps, which pins down the hold and poll timer lengths to the cycle.

// File: rtl/lts_pkg.sv
package lts_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_RDRX, S_EVAL, S_RDOV1, S_WROV1,
    S_HOLD, S_RDOV2, S_WROV2, S_WAIT, S_DONE
  } ltsState_e;

  typedef struct packed {
    logic loadPoll;
    logic loadHold;
    logic cntClr;
    logic cntInc;
    logic capture;
  } ltsStrobe_t;

  localparam logic [15:0] RX_STAT_REG = 16'h100D;
  localparam logic [15:0] OVRD_REG    = 16'h1005;
  localparam logic [15:0] OVRD_MASK   = 16'h0028;
  localparam logic [5:0]  STUCK_STATE = 6'h0D;
  localparam int          UP_BIT      = 4;
  localparam int          TRAIN_BIT   = 29;

endpackage

// File: rtl/lts_dpath.sv
module lts_dpath
  import lts_pkg::*;
#(
  parameter int POLL_CYC  = 1000,
  parameter int HOLD_CYC  = 300000,
  parameter int MAX_POLLS = 4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ltsStrobe_t  strobe,
  input  logic [15:0] phyRdata,
  output logic        timerZero,
  output logic        pollLast,
  output logic        rxValid,
  output logic [15:0] ovSet,
  output logic [15:0] ovClr
);
  localparam int TMR_MAX = (POLL_CYC > HOLD_CYC) ? POLL_CYC : HOLD_CYC;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam int CW      = $clog2(MAX_POLLS + 1);

  logic [TW-1:0] tmr;
  logic [CW-1:0] pollCnt;
  logic [15:0]   capReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (strobe.loadPoll) begin
      tmr <= TW'(POLL_CYC - 1);
    end else if (strobe.loadHold) begin
      tmr <= TW'(HOLD_CYC - 1);
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClr) begin
      pollCnt <= '0;
    end else if (strobe.cntInc) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg <= '0;
    end else if (strobe.capture) begin
      capReg <= phyRdata;
    end
  end

  assign timerZero = (tmr == '0);
  assign pollLast  = (pollCnt == CW'(MAX_POLLS - 1));
  assign rxValid   = capReg[0];
  assign ovSet     = capReg | OVRD_MASK;
  assign ovClr     = capReg & ~OVRD_MASK;

  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < CW'(MAX_POLLS));

  // R5
  hold_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadHold |=> tmr == TW'(HOLD_CYC - 1));

endmodule

// File: rtl/lts_ctrl.sv
module lts_ctrl
  import lts_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] dbgWord0,
  input  logic [31:0] dbgWord1,
  input  logic        phyAck,
  input  logic        phyErr,
  input  logic        timerZero,
  input  logic        pollLast,
  input  logic        rxValid,
  input  logic [15:0] ovSet,
  input  logic [15:0] ovClr,
  output ltsStrobe_t  strobe,
  output logic        phyReq,
  output logic        phyWe,
  output logic [15:0] phyAddr,
  output logic [15:0] phyWdata,
  output logic        done,
  output logic        linkOk,
  output logic        timeout
);
  ltsState_e st, nxt;
  logic setOk, setTo, clrRes;
  logic linkUp, stuck, accessSt;
  logic unusedDbg;

  assign unusedDbg = ^{dbgWord0[31:6], dbgWord1[31:30], dbgWord1[28:5], dbgWord1[3:0]};
  assign linkUp    = dbgWord1[UP_BIT] && !dbgWord1[TRAIN_BIT];
  assign stuck     = (dbgWord0[5:0] == STUCK_STATE) && !rxValid;
  assign accessSt  = (st == S_RDRX) || (st == S_RDOV1) || (st == S_WROV1)
                   || (st == S_RDOV2) || (st == S_WROV2);

  always_comb begin
    nxt    = st;
    strobe = '0;
    setOk  = 1'b0;
    setTo  = 1'b0;
    clrRes = 1'b0;
    if (accessSt && phyAck && phyErr) begin
      nxt = S_DONE;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          nxt = S_CHECK; strobe.cntClr = 1'b1; clrRes = 1'b1;
        end
        S_CHECK: if (linkUp) begin
          nxt = S_DONE; setOk = 1'b1;
        end else begin
          nxt = S_RDRX;
        end
        S_RDRX: if (phyAck) begin
          strobe.capture = 1'b1; nxt = S_EVAL;
        end
        S_EVAL: if (stuck) begin
          nxt = S_RDOV1;
        end else begin
          strobe.loadPoll = 1'b1; nxt = S_WAIT;
        end
        S_RDOV1: if (phyAck) begin
          strobe.capture = 1'b1; nxt = S_WROV1;
        end
        S_WROV1: if (phyAck) begin
          strobe.loadHold = 1'b1; nxt = S_HOLD;
        end
        S_HOLD: if (timerZero) nxt = S_RDOV2;
        S_RDOV2: if (phyAck) begin
          strobe.capture = 1'b1; nxt = S_WROV2;
        end
        S_WROV2: if (phyAck) begin
          strobe.loadPoll = 1'b1; nxt = S_WAIT;
        end
        S_WAIT: if (timerZero) begin
          if (pollLast) begin
            nxt = S_DONE; setTo = 1'b1;
          end else begin
            strobe.cntInc = 1'b1; nxt = S_CHECK;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      linkOk  <= 1'b0;
      timeout <= 1'b0;
    end else begin
      st <= nxt;
      if (clrRes) begin
        linkOk  <= 1'b0;
        timeout <= 1'b0;
      end else begin
        if (setOk) linkOk  <= 1'b1;
        if (setTo) timeout <= 1'b1;
      end
    end
  end

  always_comb begin
    done     = (st == S_DONE);
    phyReq   = accessSt;
    phyWe    = (st == S_WROV1) || (st == S_WROV2);
    phyAddr  = '0;
    phyWdata = '0;
    if (st == S_RDRX) phyAddr = RX_STAT_REG;
    else if (accessSt) phyAddr = OVRD_REG;
    if (st == S_WROV1) phyWdata = ovSet;
    else if (st == S_WROV2) phyWdata = ovClr;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    phyReq && !phyAck |=> phyReq && $stable(phyAddr) && $stable(phyWe) && $stable(phyWdata));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !phyReq);

  // R9
  err_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    phyReq && phyAck && phyErr |=> done && !linkOk && !timeout);

  // R8
  result_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkOk || timeout) |-> done && !(linkOk && timeout));

  // R1
  up_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_CHECK) && linkUp |=> done && linkOk);

endmodule

// File: rtl/link_train_sup.sv
module link_train_sup
  import lts_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int POLL_US    = 10,
  parameter int HOLD_US    = 3000,
  parameter int MAX_POLLS  = 4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] dbgWord0,
  input  logic [31:0] dbgWord1,
  output logic        phyReq,
  output logic        phyWe,
  output logic [15:0] phyAddr,
  output logic [15:0] phyWdata,
  input  logic        phyAck,
  input  logic        phyErr,
  input  logic [15:0] phyRdata,
  output logic        done,
  output logic        linkOk,
  output logic        timeout
);
  localparam int POLL_CYC = CLK_PER_US * POLL_US;
  localparam int HOLD_CYC = CLK_PER_US * HOLD_US;

  ltsStrobe_t  strobe;
  logic        timerZero, pollLast, rxValid;
  logic [15:0] ovSet, ovClr;

  lts_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .dbgWord0(dbgWord0), .dbgWord1(dbgWord1),
    .phyAck(phyAck), .phyErr(phyErr),
    .timerZero(timerZero), .pollLast(pollLast), .rxValid(rxValid),
    .ovSet(ovSet), .ovClr(ovClr), .strobe(strobe),
    .phyReq(phyReq), .phyWe(phyWe), .phyAddr(phyAddr), .phyWdata(phyWdata),
    .done(done), .linkOk(linkOk), .timeout(timeout)
  );

  lts_dpath #(
    .POLL_CYC(POLL_CYC), .HOLD_CYC(HOLD_CYC), .MAX_POLLS(MAX_POLLS)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phyRdata(phyRdata),
    .timerZero(timerZero), .pollLast(pollLast), .rxValid(rxValid),
    .ovSet(ovSet), .ovClr(ovClr)
  );

endmodule

// File: tb/link_train_sup_tb_top.sv
module link_train_sup_tb_top;
  localparam int CPU   = 1;
  localparam int PUS   = 4;
  localparam int HUS   = 12;
  localparam int MAXP  = 3;
  localparam int POLLC = CPU * PUS;
  localparam int HOLDC = CPU * HUS;
  localparam logic [15:0] OV_INIT = 16'h1A0E;
  localparam logic [15:0] FLIP    = 16'h0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] dbgWord0 = '0, dbgWord1 = '0;
  logic phyReq, phyWe, phyAck = 1'b0, phyErr = 1'b0;
  logic [15:0] phyAddr, phyWdata, phyRdata = '0;
  logic done, linkOk, timeout;

  always #2 clk = ~clk;

  link_train_sup #(.CLK_PER_US(CPU), .POLL_US(PUS), .HOLD_US(HUS), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dbgWord0(dbgWord0), .dbgWord1(dbgWord1),
    .phyReq(phyReq), .phyWe(phyWe), .phyAddr(phyAddr), .phyWdata(phyWdata),
    .phyAck(phyAck), .phyErr(phyErr), .phyRdata(phyRdata),
    .done(done), .linkOk(linkOk), .timeout(timeout)
  );

  int compared = 0, mismatched = 0;
  int cycles = 0;

  // PHY model state
  logic        rxVal = 1'b1;
  logic [15:0] ovReg = OV_INIT;
  logic        errNext = 1'b0;
  int rxReads = 0, ovReads = 0, ovWrites = 0, badAddr = 0;
  int lowCnt = 0, waitCnt = 0, unstable = 0;
  int rxGap = -1, holdGap = -1;
  logic [15:0] wr1 = '0, wr2 = '0, hAddr = '0, hWd = '0, lastAddr = '0;
  logic hWe = 1'b0, lastWe = 1'b1;

  always @(negedge clk) begin
    if (!phyReq) lowCnt++;
    if (phyAck) begin
      phyAck = 1'b0;
      phyErr = 1'b0;
    end else if (phyReq) begin
      if (waitCnt == 0) begin
        hAddr = phyAddr; hWe = phyWe; hWd = phyWdata;
      end else if (hAddr != phyAddr || hWe != phyWe || hWd != phyWdata) begin
        unstable++;
      end
      if (waitCnt < 2) begin
        waitCnt++;
      end else begin
        waitCnt = 0;
        phyAck = 1'b1;
        phyErr = errNext;
        errNext = 1'b0;
        if (phyWe) begin
          if (phyAddr == 16'h1005) begin
            ovWrites++;
            if (ovWrites == 1) begin wr1 = phyWdata; ovReg = phyWdata ^ FLIP; end
            else begin
              if (ovWrites == 2) wr2 = phyWdata;
              ovReg = phyWdata;
            end
          end else badAddr++;
        end else if (phyAddr == 16'h100D) begin
          rxReads++;
          if (lastAddr == 16'h100D && !lastWe) rxGap = lowCnt;
          phyRdata = {15'h5A5A, rxVal};
        end else if (phyAddr == 16'h1005) begin
          ovReads++;
          if (ovReads == 2) holdGap = lowCnt;
          phyRdata = ovReg;
        end else badAddr++;
        lastAddr = phyAddr; lastWe = phyWe;
        lowCnt = 0;
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clrModel();
    rxReads = 0; ovReads = 0; ovWrites = 0; rxGap = -1; holdGap = -1;
    ovReg = OV_INIT; wr1 = '0; wr2 = '0; lastAddr = '0; lastWe = 1'b1;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 done", done, 0); chk("R12 linkOk", linkOk, 0);
    chk("R12 timeout", timeout, 0); chk("R12 phyReq", phyReq, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Exhaustive sweep: link bits x receive valid x state code
    for (int b = 0; b < 4; b++) begin
      for (int rv = 0; rv < 2; rv++) begin
        for (int s = 0; s < 2; s++) begin
          logic up, stk;
          up  = (b == 1);
          stk = (s == 0) && (rv == 0);
          @(negedge clk);
          clrModel();
          dbgWord1 = 32'h0000_0000 | (32'(b & 1) << 4) | (32'(b >> 1) << 29) | 32'h0240_0101;
          dbgWord0 = {26'h2B7_1C4 ^ 26'(b * 7 + rv), (s == 0) ? 6'h0D : 6'h0C};
          rxVal = rv[0];
          pulseStart();
          waitDone();
          chk("R1/R8 done", done, 1);
          chk("R1 linkOk", linkOk, up);
          chk("R8 timeout", timeout, !up);
          chk("R2 rx reads", rxReads, up ? 0 : MAXP);
          chk("R3 override writes", ovWrites, (!up && stk) ? 2 * MAXP : 0);
          if (!up && stk) begin
            chk("R4 set write", wr1, OV_INIT | 16'h0028);
            chk("R6 clear write", wr2, ((OV_INIT | 16'h0028) ^ FLIP) & ~16'h0028);
            chk("R5 hold gap", holdGap, HOLDC);
          end
          if (!up && !stk) chk("R7 poll gap", rxGap, POLLC + 2);
        end
      end
    end

    // R11 results held after finishing
    repeat (20) @(negedge clk);
    chk("R11 held done", done, 1);
    chk("R11 held timeout", timeout, 1);
    chk("R10 no request while done", phyReq, 0);

    // Link comes up after the first poll
    clrModel();
    dbgWord1 = '0; dbgWord0 = 32'h0000_0003; rxVal = 1'b1;
    pulseStart();
    for (int i = 0; i < 2000 && rxReads == 0; i++) @(negedge clk);
    dbgWord1 = 32'h0000_0010;
    waitDone();
    chk("R1 late up linkOk", linkOk, 1);
    chk("R11 restart cleared timeout", timeout, 0);
    chk("R2 single read before up", rxReads, 1);

    // R9 access error on the first read
    clrModel();
    dbgWord1 = '0; errNext = 1'b1;
    pulseStart();
    waitDone();
    chk("R9 done", done, 1);
    chk("R9 linkOk", linkOk, 0);
    chk("R9 timeout", timeout, 0);
    repeat (30) @(negedge clk);
    chk("R9 no further reads", rxReads, 1);
    chk("R9 still done", done, 1);

    chk("R10 request stable until ack", unstable, 0);
    chk("R2 legal addresses", badAddr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule